// File: doc/BRIEF.md
# Ping-Pong PCM DMA Address Generator

This block produces the memory fetch addresses for one PCM audio stream. A host programs two independent transfer areas, each with a 32-bit start address and a 16-bit byte length, together with a sample format and a run control. On every sample tick while running, the block requests one sample's worth of bytes at the current position. It then advances the position by the sample size that the format implies.

When the active area is used up, the block marks that area's completion flag. It switches to the other area's start address on the same edge, so the stream has no gap. From area 2 it returns to area 1, and the two areas keep alternating in this way. The host acknowledges a completion by writing a 1 to the flag's bit. The interrupt output stays high while either flag is pending. The bus master, sample buffering and rate clock sit outside the block. The block only names the address and the byte count for each sample.

Registers are 16 bits wide and are addressed by a byte offset. Bit 0 of the offset is ignored. Each 32-bit quantity takes two halfwords, with the low half at the lower offset.

Top module: `pingpong_dma_engine`

## Requirements
- R1: After reset, every register reads zero except the format register, which reads 0x0010. The interrupt output is low, no fetch is requested, and the position is 0.
- R2: The control register at offset 0x00 stores bit 0 (run) and bits 5:2 (spare storage). Bit 1 always reads 0 and bits 15:6 read 0. The format register at 0x16 keeps only bits 5:0, and its other bits read 0. The interrupt register at 0x02 reads zero except bits 2:1. The position at 0x10/0x12 and the offset at 0x14 cannot be written.
- R3: The byte step per sample comes from format bit 4 (16-bit) and bit 5 (stereo). The step is 1 when both are clear, 2 when exactly one is set, and 4 when both are set.
- R4: A sample tick is accepted only while run (control bit 0) is 1. While run is 0, ticks cause no fetch, and the position and offset hold their values. Setting run again resumes from the held position.
- R5: Each accepted fetch adds the step to the offset. The completing fetch is the one after which the offset would reach or pass the active area's length. On that fetch, the area's flag is set, the position loads the other area's start, and the offset returns to 0. Area 1 is followed by area 2, and area 2 by area 1.
- R6: The interrupt register holds the area-1 completion flag in bit 1 and the area-2 flag in bit 2. Writing a 1 to a bit clears that flag, and writing 0xFFFF clears both. A completion in the same cycle as the clear wins, and its flag stays set.
- R7: An area whose length is 0 transfers nothing, but its flag is still set. If it is the next area at a completion, both flags are set and the position reloads the current area's start. If it is the active area when a tick is accepted, no fetch is made, its flag is set, and the engine moves to the other area.
- R8: The interrupt output is high exactly when at least one completion flag is set.
- R9: Writing the control register with bit 1 set rewinds the engine. Area 1 becomes active, the position loads area 1's start, and the offset clears. A rewind takes priority over a tick in the same cycle.
- R10: A fetch request is a one-cycle pulse in the cycle after the accepted tick. It carries the position from before the advance, and the step as the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i (combinational) |
| sample_tick_i | input | 1 | One pulse per sample period |
| fetch_req_o | output | 1 | Fetch request pulse |
| fetch_addr_o | output | 32 | Byte address of the requested sample |
| fetch_bytes_o | output | 3 | Bytes in the requested sample |
| irq_o | output | 1 | Completion interrupt |

## Verification
The position is driven through two areas with unequal lengths and widely separated starts. This shows whether the switch and the wrap each load the correct start, and whether each area sets its own flag. All four formats are run from the same rewound start, so any error in the step decode shows up as a distinct second fetch address. A zero-length area is tried both as the next area and as the active area, since the two paths differ in which start is loaded and whether a fetch occurs. Pause, masked writes and partial acknowledges are each followed by reads of the position, offset and flags, to show that nothing else moved.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int DATA_W = 16;
  localparam int REG_AW = 5;
  localparam int STEP_W = 3;

  // halfword indices (byte offset >> 1)
  localparam logic [3:0] IX_CTRL = 4'd0;
  localparam logic [3:0] IX_IRQ  = 4'd1;
  localparam logic [3:0] IX_S1L  = 4'd2;
  localparam logic [3:0] IX_S1H  = 4'd3;
  localparam logic [3:0] IX_S2L  = 4'd4;
  localparam logic [3:0] IX_S2H  = 4'd5;
  localparam logic [3:0] IX_LEN1 = 4'd6;
  localparam logic [3:0] IX_LEN2 = 4'd7;
  localparam logic [3:0] IX_POSL = 4'd8;
  localparam logic [3:0] IX_POSH = 4'd9;
  localparam logic [3:0] IX_OFS  = 4'd10;
  localparam logic [3:0] IX_FMT  = 4'd11;

  localparam logic [5:0] FMT_RESET = 6'h10;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [LEN_W-1:0]  len;
  } area_cfg_t;
endpackage

// File: rtl/pp_dma_step.sv
module pp_dma_step
  import pp_dma_pkg::*;
(
  input  logic              wide_i,
  input  logic              stereo_i,
  output logic [STEP_W-1:0] step_o
);
  always_comb begin
    unique case ({stereo_i, wide_i})
      2'b00:   step_o = STEP_W'(1);
      2'b01,
      2'b10:   step_o = STEP_W'(2);
      default: step_o = STEP_W'(4);
    endcase
  end
endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
  import pp_dma_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [1:0]           done_i,
  input  logic [ADDR_W-1:0]    pos_i,
  input  logic [LEN_W-1:0]     ofs_i,
  output area_cfg_t [1:0]      cfg_o,
  output logic                 run_o,
  output logic                 rewind_o,
  output logic [5:0]           fmt_o,
  output logic [1:0]           flag_o
);
  logic [3:0] idx;
  logic [3:0] spare_q;
  logic       run_q;
  logic [5:0] fmt_q;
  logic [1:0] flag_q;
  area_cfg_t [1:0] cfg_q;

  assign idx = addr_i[REG_AW-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      spare_q <= '0;
      fmt_q   <= FMT_RESET;
      cfg_q   <= '0;
    end else if (wr_i) begin
      unique case (idx)
        IX_CTRL: begin
          run_q   <= wdata_i[0];
          spare_q <= wdata_i[5:2];
        end
        IX_S1L:  cfg_q[0].start[15:0]  <= wdata_i;
        IX_S1H:  cfg_q[0].start[31:16] <= wdata_i;
        IX_S2L:  cfg_q[1].start[15:0]  <= wdata_i;
        IX_S2H:  cfg_q[1].start[31:16] <= wdata_i;
        IX_LEN1: cfg_q[0].len <= wdata_i;
        IX_LEN2: cfg_q[1].len <= wdata_i;
        IX_FMT:  fmt_q <= wdata_i[5:0];
        default: ;
      endcase
    end
  end

  // completion beats acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else begin
      for (int i = 0; i < 2; i++) begin
        if (done_i[i]) flag_q[i] <= 1'b1;
        else if (wr_i && idx == IX_IRQ && wdata_i[i+1]) flag_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      IX_CTRL: rdata_o = {10'd0, spare_q, 1'b0, run_q};
      IX_IRQ:  rdata_o = {13'd0, flag_q, 1'b0};
      IX_S1L:  rdata_o = cfg_q[0].start[15:0];
      IX_S1H:  rdata_o = cfg_q[0].start[31:16];
      IX_S2L:  rdata_o = cfg_q[1].start[15:0];
      IX_S2H:  rdata_o = cfg_q[1].start[31:16];
      IX_LEN1: rdata_o = cfg_q[0].len;
      IX_LEN2: rdata_o = cfg_q[1].len;
      IX_POSL: rdata_o = pos_i[15:0];
      IX_POSH: rdata_o = pos_i[31:16];
      IX_OFS:  rdata_o = ofs_i;
      IX_FMT:  rdata_o = {10'd0, fmt_q};
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign run_o    = run_q;
  assign rewind_o = wr_i && idx == IX_CTRL && wdata_i[1];
  assign fmt_o    = fmt_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/pp_dma_pos.sv
module pp_dma_pos
  import pp_dma_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               rewind_i,
  input  logic               tick_i,
  input  logic [STEP_W-1:0]  step_i,
  input  area_cfg_t [1:0]    cfg_i,
  output logic [ADDR_W-1:0]  pos_o,
  output logic [LEN_W-1:0]   ofs_o,
  output logic [1:0]         done_o,
  output logic               req_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [STEP_W-1:0]  bytes_o
);
  logic              area_q, area_n;
  logic [ADDR_W-1:0] pos_q, pos_n, addr_q, addr_n;
  logic [LEN_W-1:0]  ofs_q, ofs_n;
  logic [LEN_W:0]    ofs_sum;
  logic              req_q, req_n, finish;
  logic [STEP_W-1:0] bytes_q, bytes_n;
  logic [LEN_W-1:0]  act_len, oth_len;

  always_comb begin
    act_len = cfg_i[area_q].len;
    oth_len = cfg_i[~area_q].len;
    ofs_sum = {1'b0, ofs_q} + (LEN_W+1)'(step_i);
    area_n  = area_q;
    pos_n   = pos_q;
    ofs_n   = ofs_q;
    addr_n  = addr_q;
    bytes_n = bytes_q;
    req_n   = 1'b0;
    finish  = 1'b0;
    done_o  = '0;
    if (rewind_i) begin
      area_n = 1'b0;
      pos_n  = cfg_i[0].start;
      ofs_n  = '0;
    end else if (run_i && tick_i) begin
      if (act_len == '0) begin
        finish = 1'b1;
      end else begin
        req_n   = 1'b1;
        addr_n  = pos_q;
        bytes_n = step_i;
        if (ofs_sum >= {1'b0, act_len}) finish = 1'b1;
        else begin
          pos_n = pos_q + ADDR_W'(step_i);
          ofs_n = ofs_sum[LEN_W-1:0];
        end
      end
      if (finish) begin
        done_o[area_q] = 1'b1;
        ofs_n = '0;
        if (oth_len == '0) begin
          done_o[~area_q] = 1'b1;
          pos_n = cfg_i[area_q].start;
        end else begin
          area_n = ~area_q;
          pos_n  = cfg_i[~area_q].start;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      area_q  <= 1'b0;
      pos_q   <= '0;
      ofs_q   <= '0;
      req_q   <= 1'b0;
      addr_q  <= '0;
      bytes_q <= '0;
    end else begin
      area_q  <= area_n;
      pos_q   <= pos_n;
      ofs_q   <= ofs_n;
      req_q   <= req_n;
      addr_q  <= addr_n;
      bytes_q <= bytes_n;
    end
  end

  assign pos_o   = pos_q;
  assign ofs_o   = ofs_q;
  assign req_o   = req_q;
  assign addr_o  = addr_q;
  assign bytes_o = bytes_q;
endmodule

// File: rtl/pingpong_dma_engine.sv
module pingpong_dma_engine
  import pp_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              sample_tick_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [STEP_W-1:0] fetch_bytes_o,
  output logic              irq_o
);
  area_cfg_t [1:0]   cfg;
  logic              run, rewind;
  logic [5:0]        fmt;
  logic [1:0]        flag, done;
  logic [ADDR_W-1:0] pos;
  logic [LEN_W-1:0]  ofs;
  logic [STEP_W-1:0] step;

  pp_dma_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .done_i(done),
    .pos_i(pos), .ofs_i(ofs), .cfg_o(cfg), .run_o(run), .rewind_o(rewind),
    .fmt_o(fmt), .flag_o(flag)
  );

  pp_dma_step u_step (.wide_i(fmt[4]), .stereo_i(fmt[5]), .step_o(step));

  pp_dma_pos u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .rewind_i(rewind),
    .tick_i(sample_tick_i), .step_i(step), .cfg_i(cfg), .pos_o(pos),
    .ofs_o(ofs), .done_o(done), .req_o(fetch_req_o), .addr_o(fetch_addr_o),
    .bytes_o(fetch_bytes_o)
  );

  assign irq_o = |flag;
endmodule

// File: rtl/pp_dma_chk.sv
module pp_dma_chk
  import pp_dma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              sample_tick_i,
  input logic              fetch_req_o,
  input logic              irq_o,
  input logic              run_i,
  input logic [ADDR_W-1:0] pos_i,
  input logic [LEN_W-1:0]  ofs_i
);
  p_req_after_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> $past(sample_tick_i && run_i));

  p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(reg_wr_i && reg_addr_i[4:1] == IX_IRQ)) |=> irq_o);

  p_pause_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reg_wr_i) |=> ($stable(pos_i) && $stable(ofs_i) && !fetch_req_o));

  p_rewind_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i[4:1] == IX_CTRL && reg_wdata_i[1]) |=> (ofs_i == '0));

  p_fmt_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i[4:1] == IX_FMT) |-> (reg_rdata_o[15:6] == '0));
endmodule

bind pingpong_dma_engine pp_dma_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .sample_tick_i(sample_tick_i), .fetch_req_o(fetch_req_o), .irq_o(irq_o),
  .run_i(run), .pos_i(pos), .ofs_i(ofs)
);

// File: tb/sim_pingpong_dma_engine.sv
`timescale 1ns/1ps
module sim_pingpong_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick = 1'b0;
  logic        req;
  logic [31:0] faddr;
  logic [2:0]  fbytes;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  pingpong_dma_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sample_tick_i(tick),
    .fetch_req_o(req), .fetch_addr_o(faddr), .fetch_bytes_o(fbytes), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, logic [15:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, {16'd0, rdata}, {16'd0, exp});
  endtask

  task automatic rd_pos(logic [31:0] exp, string tag);
    logic [31:0] v;
    @(negedge clk); addr = 5'h10; #1; v[15:0] = rdata;
    addr = 5'h12; #1; v[31:16] = rdata;
    chk(tag, v, exp);
  endtask

  // one tick; returns request flag and address seen the next cycle
  task automatic do_tick(output logic r, output logic [31:0] a, output logic [2:0] b);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; r = req; a = faddr; b = fbytes;
  endtask

  task automatic tick_exp(logic [31:0] exp_a, string tag);
    logic r; logic [31:0] a; logic [2:0] b;
    do_tick(r, a, b);
    chk({tag, " req"}, {31'd0, r}, 32'd1);
    chk({tag, " addr"}, a, exp_a);
  endtask

  task automatic setup_areas(logic [31:0] s1, logic [31:0] s2, logic [15:0] l1, logic [15:0] l2);
    wr_reg(5'h04, s1[15:0]); wr_reg(5'h06, s1[31:16]);
    wr_reg(5'h08, s2[15:0]); wr_reg(5'h0A, s2[31:16]);
    wr_reg(5'h0C, l1); wr_reg(5'h0E, l2);
  endtask

  task automatic t_reset;
    rd_reg(5'h16, 16'h0010, "R1 format");
    rd_reg(5'h00, 16'h0000, "R1 ctrl");
    rd_reg(5'h02, 16'h0000, "R1 irqreg");
    rd_pos(32'h0, "R1 pos");
    chk("R1 irq_o", {31'd0, irq}, 32'd0);
    chk("R1 req", {31'd0, req}, 32'd0);
  endtask

  task automatic t_masks;
    wr_reg(5'h16, 16'hFFFF); rd_reg(5'h16, 16'h003F, "R2 format mask");
    wr_reg(5'h16, 16'h0010);
    wr_reg(5'h00, 16'hFFFD); rd_reg(5'h00, 16'h003D, "R2 ctrl mask");
    wr_reg(5'h00, 16'h0000);
    wr_reg(5'h10, 16'hBEEF); wr_reg(5'h14, 16'h1234);
    rd_pos(32'h0, "R2 pos read-only");
    rd_reg(5'h14, 16'h0000, "R2 ofs read-only");
    rd_reg(5'h02, 16'h0000, "R2 irq reg upper");
  endtask

  task automatic t_pingpong;
    setup_areas(32'h0000_1000, 32'h0002_2000, 16'd8, 16'd4);
    wr_reg(5'h00, 16'h0003);
    tick_exp(32'h1000, "R10 a1 f0");
    tick_exp(32'h1002, "R5 a1 f1");
    tick_exp(32'h1004, "R5 a1 f2");
    chk("R8 irq before done", {31'd0, irq}, 32'd0);
    tick_exp(32'h1006, "R5 a1 f3");
    chk("R8 irq after a1", {31'd0, irq}, 32'd1);
    rd_reg(5'h02, 16'h0002, "R5 flag1");
    rd_pos(32'h0002_2000, "R5 switch to a2");
    tick_exp(32'h0002_2000, "R5 a2 f0");
    tick_exp(32'h0002_2002, "R5 a2 f1");
    rd_reg(5'h02, 16'h0006, "R5 flag2");
    rd_pos(32'h1000, "R5 wrap to a1");
    rd_reg(5'h14, 16'h0000, "R5 ofs cleared");
  endtask

  task automatic t_ack;
    wr_reg(5'h02, 16'h0002);
    rd_reg(5'h02, 16'h0004, "R6 partial ack");
    chk("R8 irq one flag", {31'd0, irq}, 32'd1);
    wr_reg(5'h02, 16'hFFFF);
    rd_reg(5'h02, 16'h0000, "R6 ack all");
    chk("R8 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_pause;
    logic r; logic [31:0] a; logic [2:0] b;
    wr_reg(5'h00, 16'h0000);
    do_tick(r, a, b);
    chk("R4 no req paused", {31'd0, r}, 32'd0);
    rd_pos(32'h1000, "R4 pos held");
    wr_reg(5'h00, 16'h0001);
    tick_exp(32'h1000, "R4 resume");
    rd_reg(5'h14, 16'h0002, "R4 ofs after resume");
    wr_reg(5'h00, 16'h0003);
    rd_pos(32'h1000, "R9 rewind pos");
    rd_reg(5'h14, 16'h0000, "R9 rewind ofs");
  endtask

  task automatic t_steps;
    logic [15:0] fmts [4] = '{16'h0000, 16'h0010, 16'h0020, 16'h0030};
    int steps [4] = '{1, 2, 2, 4};
    for (int i = 0; i < 4; i++) begin
      logic r; logic [31:0] a; logic [2:0] b;
      wr_reg(5'h16, fmts[i]);
      wr_reg(5'h00, 16'h0003);
      do_tick(r, a, b);
      chk("R3 byte count", {29'd0, b}, 32'(steps[i]));
      do_tick(r, a, b);
      chk("R3 second addr", a, 32'h1000 + 32'(steps[i]));
    end
    wr_reg(5'h16, 16'h0010);
    wr_reg(5'h02, 16'hFFFF);
  endtask

  task automatic t_zero;
    logic r; logic [31:0] a; logic [2:0] b;
    setup_areas(32'h0000_1000, 32'h0002_2000, 16'd4, 16'd0);
    wr_reg(5'h00, 16'h0003);
    tick_exp(32'h1000, "R7 a1 f0");
    tick_exp(32'h1002, "R7 a1 f1");
    rd_reg(5'h02, 16'h0006, "R7 both flags");
    rd_pos(32'h1000, "R7 reload a1");
    tick_exp(32'h1000, "R7 restart a1");
    wr_reg(5'h02, 16'hFFFF);
    setup_areas(32'h0000_1000, 32'h0002_2000, 16'd0, 16'd4);
    wr_reg(5'h00, 16'h0003);
    do_tick(r, a, b);
    chk("R7 no fetch empty", {31'd0, r}, 32'd0);
    rd_reg(5'h02, 16'h0002, "R7 empty flag");
    rd_pos(32'h0002_2000, "R7 moved to a2");
    wr_reg(5'h02, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_masks;
    t_pingpong;
    t_ack;
    t_pause;
    t_steps;
    t_zero;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule